// File: doc/BRIEF.md
# Serial Test Pattern Generator with Error Injection

This block is the transmit half of a bit error rate tester. It sends a bit-serial pseudo-random stream that a far-end checker can lock onto and compare. The stream comes from a 32-bit linear feedback shift register. Its feedback taps and restart seed are supplied on plain configuration inputs. One bit is delivered for every accepted transfer on a valid/ready output.

An 8-bit control word is written through a single-cycle write strobe. Its top three bits select automatic error injection. The setting is either off or one inverted bit in every 10^n transferred bits, for n from 1 to 7. A separate command bit inverts exactly one bit, and it acts on its 0-to-1 transition only. A third command bit restarts the pattern from the seed, also on its 0-to-1 transition. An injected error flips only the bit that leaves the block. The register sequence that the far end predicts is never touched.

The output is a stream with back-pressure. `tx_valid` rises on the first clock after reset and stays high. A bit moves only on a cycle where `tx_ready` is high. While `tx_ready` is low, the bit on `tx_bit` is held, the pattern does not advance and the error spacing does not count. A configuration write is the only thing that can change `tx_bit` during a stall.

Top module: `bert_patgen`

## Requirements
- R1: During reset `tx_valid` is 0. On the first clock after reset `tx_valid` becomes 1, and the pattern register holds `RESET_SEED` (default 32'hACE1_0001).
- R2: Control bits 3:1 are discarded. Writing them changes neither the stream nor the error placement.
- R3: The generated bit is bit 31 of the pattern register. On each transfer the register shifts left by one, and the parity of (register AND `tap_mask`) enters bit 0.
- R4: While `tx_valid` is 1 and `tx_ready` is 0, `tx_bit` holds its value unless a control write occurs. Neither the pattern nor the error spacing advances.
- R5: A write in which bit 0 is 1 while the stored bit 0 is 0 loads `seed` into the pattern register on that clock. Writing bit 0 as 1 again while it is already 1 does nothing.
- R6: Rate code 000 in bits 7:5 produces no automatic errors.
- R7: Rate code n (1 to 7) inverts every 10^n-th transferred bit.
- R8: A write that changes the rate code restarts the spacing. The first automatic error then falls on the 10^n-th transfer after that write.
- R9: A write in which bit 4 is 1 while the stored bit 4 is 0 inverts exactly one bit, the next one transferred. Writing bit 4 as 1 again while it is already 1 inverts nothing.
- R10: A single error that lands on the same bit as an automatic error inverts that bit once only.
- R11: Injected errors never disturb the pattern register. After any error, the stream continues with the uninverted sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control write strobe, one cycle per write |
| cfg_wdata | input | 8 | Control word: [7:5] rate code, [4] single error, [3:1] discarded, [0] pattern restart |
| tap_mask | input | 32 | Feedback tap mask for the pattern register |
| seed | input | 32 | Value loaded by the restart command |
| tx_valid | output | 1 | Output bit valid |
| tx_ready | input | 1 | Sink accepts the bit on this cycle |
| tx_bit | output | 1 | Generated bit, with any injected error |

## Verification
The bench aims at the edge-triggered commands. It holds each command bit high across repeated writes; a level-sensitive design would then reload the pattern or keep inverting bits. It lines up a single error with the terminal count of the rate-1 spacing, where a design that XORs the two sources would cancel the error. It also changes the rate midway through an interval, which a design without restart would get wrong by placing the first error early. Random stalls with a single error pending check that the error is neither lost nor spent on a bit that was never transferred. Each injected error is followed by a check that the stream returns to the clean sequence, which catches a design that flips the stored pattern.

// File: rtl/bert_pkg.sv
package bert_pkg;
  localparam int CTRL_W     = 8;
  localparam int RATE_W     = 3;
  localparam int RATE_LSB   = 5;
  localparam int SHOT_BIT   = 4;
  localparam int RESEED_BIT = 0;

  // 10^n, evaluated at elaboration for counter reload values
  function automatic int pow10(input int n);
    int acc;
    acc = 1;
    for (int i = 0; i < n; i++) acc = acc * 10;
    return acc;
  endfunction
endpackage

// File: rtl/bert_ctrl_reg.sv
module bert_ctrl_reg
  import bert_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [RATE_W-1:0] wr_rate,
  input  logic              wr_shot,
  input  logic              wr_reseed,
  input  logic              xfer,
  output logic [RATE_W-1:0] rate_q,
  output logic              rate_wr,
  output logic              shot_q,
  output logic              reseed_q,
  output logic              reseed_go,
  output logic              shot_pend
);
  logic shot_rise;

  assign rate_wr   = we && (wr_rate != rate_q);
  assign shot_rise = we && wr_shot && !shot_q;
  assign reseed_go = we && wr_reseed && !reseed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q    <= '0;
      shot_q    <= 1'b0;
      reseed_q  <= 1'b0;
      shot_pend <= 1'b0;
    end else begin
      if (we) begin
        rate_q   <= wr_rate;
        shot_q   <= wr_shot;
        reseed_q <= wr_reseed;
      end
      // an arming edge wins over consumption on the same clock
      shot_pend <= shot_rise || (shot_pend && !xfer);
    end
  end
endmodule

// File: rtl/bert_err_spacer.sv
module bert_err_spacer
  import bert_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RATE_W-1:0] rate_q,
  input  logic              rate_wr,
  input  logic [RATE_W-1:0] new_rate,
  input  logic              xfer,
  output logic              auto_hit
);
  localparam int CODES = 2 ** RATE_W;

  logic [CNT_W-1:0] reload_tab [CODES];
  logic [CNT_W-1:0] cnt;

  generate
    for (genvar g = 0; g < CODES; g++) begin : g_tab
      assign reload_tab[g] = CNT_W'(pow10(g));
    end
  endgenerate

  assign auto_hit = (rate_q != '0) && (cnt == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt <= CNT_W'(1);
    else if (rate_wr)              cnt <= reload_tab[new_rate];
    else if (xfer && rate_q != '0) cnt <= auto_hit ? reload_tab[rate_q] : cnt - CNT_W'(1);
  end
endmodule

// File: rtl/bert_lfsr.sv
module bert_lfsr #(
  parameter int               PAT_W      = 32,
  parameter logic [PAT_W-1:0] RESET_SEED = 32'hACE1_0001
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PAT_W-1:0] taps,
  input  logic [PAT_W-1:0] seed,
  input  logic             load,
  input  logic             step,
  output logic             msb
);
  logic [PAT_W-1:0] state;
  logic             fb;

  assign fb  = ^(state & taps);
  assign msb = state[PAT_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    state <= RESET_SEED;
    else if (load) state <= seed;
    else if (step) state <= {state[PAT_W-2:0], fb};
  end
endmodule

// File: rtl/bert_patgen.sv
module bert_patgen
  import bert_pkg::*;
#(
  parameter int               PAT_W      = 32,
  parameter logic [PAT_W-1:0] RESET_SEED = 32'hACE1_0001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CTRL_W-1:0] cfg_wdata,
  input  logic [PAT_W-1:0]  tap_mask,
  input  logic [PAT_W-1:0]  seed,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic              tx_bit
);
  localparam int CNT_W = $clog2(pow10(2 ** RATE_W - 1) + 1);

  logic              xfer, auto_hit, shot_pend, lfsr_msb;
  logic              rate_wr, shot_q, reseed_q, reseed_go;
  logic [RATE_W-1:0] rate_q;
  logic              unused_rsvd;

  assign unused_rsvd = ^cfg_wdata[SHOT_BIT-1:RESEED_BIT+1];
  assign xfer        = tx_valid && tx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_valid <= 1'b0;
    else        tx_valid <= 1'b1;
  end

  bert_ctrl_reg u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (cfg_we),
    .wr_rate   (cfg_wdata[RATE_LSB +: RATE_W]),
    .wr_shot   (cfg_wdata[SHOT_BIT]),
    .wr_reseed (cfg_wdata[RESEED_BIT]),
    .xfer      (xfer),
    .rate_q    (rate_q),
    .rate_wr   (rate_wr),
    .shot_q    (shot_q),
    .reseed_q  (reseed_q),
    .reseed_go (reseed_go),
    .shot_pend (shot_pend)
  );

  bert_err_spacer #(.CNT_W(CNT_W)) u_space (
    .clk      (clk),
    .rst_n    (rst_n),
    .rate_q   (rate_q),
    .rate_wr  (rate_wr),
    .new_rate (cfg_wdata[RATE_LSB +: RATE_W]),
    .xfer     (xfer),
    .auto_hit (auto_hit)
  );

  bert_lfsr #(.PAT_W(PAT_W), .RESET_SEED(RESET_SEED)) u_pat (
    .clk   (clk),
    .rst_n (rst_n),
    .taps  (tap_mask),
    .seed  (seed),
    .load  (reseed_go),
    .step  (xfer),
    .msb   (lfsr_msb)
  );

  // one inversion whichever source asks, the stored pattern is untouched
  assign tx_bit = lfsr_msb ^ (auto_hit | shot_pend);
endmodule

// File: rtl/bert_patgen_chk.sv
module bert_patgen_chk
  import bert_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic              wr_shot,
  input logic              wr_reseed,
  input logic              seed_msb,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic              tx_bit,
  input logic [RATE_W-1:0] rate_q,
  input logic              shot_q,
  input logic              reseed_q,
  input logic              shot_pend,
  input logic              auto_hit,
  input logic              lfsr_msb
);
  a_r1_valid_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> tx_valid);

  a_r4_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !cfg_we) |=> $stable(tx_bit));

  a_r5_reseed_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && wr_reseed && !reseed_q) |=> (lfsr_msb == $past(seed_msb)));

  a_r6_off_means_no_auto: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_q == '0) |-> !auto_hit);

  a_r9_shot_arms: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && wr_shot && !shot_q) |=> shot_pend);

  a_r9_shot_spent: assert property (@(posedge clk) disable iff (!rst_n)
    (shot_pend && tx_valid && tx_ready && !cfg_we) |=> !shot_pend);
endmodule

bind bert_patgen bert_patgen_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .wr_shot   (cfg_wdata[4]),
  .wr_reseed (cfg_wdata[0]),
  .seed_msb  (seed[PAT_W-1]),
  .tx_valid  (tx_valid),
  .tx_ready  (tx_ready),
  .tx_bit    (tx_bit),
  .rate_q    (rate_q),
  .shot_q    (shot_q),
  .reseed_q  (reseed_q),
  .shot_pend (shot_pend),
  .auto_hit  (auto_hit),
  .lfsr_msb  (lfsr_msb)
);

// File: tb/tb_bert_patgen.sv
`timescale 1ns/1ps
module tb_bert_patgen;
  localparam logic [31:0] RST_SEED = 32'hACE1_0001;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_wdata = '0;
  logic [31:0] tap_mask = 32'h8020_0003;
  logic [31:0] seed = 32'h1234_5678;
  logic        tx_ready = 1'b0;
  logic        tx_valid, tx_bit;

  always #2.5 clk = ~clk;

  bert_patgen dut (.*);

  int errors = 0, checks = 0, inv_cnt = 0;
  string cur_req = "R3";
  bit done = 1'b0;

  // behavioural reference, updated at negedge for the coming posedge
  logic [31:0] m_pat;
  int          m_cnt;
  logic [2:0]  m_rate;
  bit          m_shot, m_reseed, m_pend, m_valid;

  function automatic int dec(input int n);
    int v = 1;
    for (int i = 0; i < n; i++) v *= 10;
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      m_pat = RST_SEED; m_cnt = 1; m_rate = 0;
      m_shot = 0; m_reseed = 0; m_pend = 0; m_valid = 0;
    end else begin
      bit inj, hs, exp_bit;
      inj = ((m_rate != 0) && (m_cnt == 1)) || m_pend;
      exp_bit = m_pat[31] ^ inj;
      chk(tx_valid == m_valid, "R1", tx_valid, m_valid);
      if (m_valid) chk(tx_bit == exp_bit, cur_req, tx_bit, exp_bit);
      hs = m_valid && tx_ready;
      if (hs && (tx_bit != m_pat[31])) inv_cnt++;
      // next state
      if (cfg_we && cfg_wdata[0] && !m_reseed) m_pat = seed;
      else if (hs) m_pat = {m_pat[30:0], ^(m_pat & tap_mask)};
      if (cfg_we && cfg_wdata[7:5] != m_rate) m_cnt = dec(cfg_wdata[7:5]);
      else if (hs && m_rate != 0) m_cnt = (m_cnt == 1) ? dec(m_rate) : m_cnt - 1;
      m_pend = (cfg_we && cfg_wdata[4] && !m_shot) || (m_pend && !hs);
      if (cfg_we) begin
        m_rate = cfg_wdata[7:5]; m_shot = cfg_wdata[4]; m_reseed = cfg_wdata[0];
      end
      m_valid = 1'b1;
    end
  end

  task automatic step(); @(posedge clk); #1; endtask
  task automatic wr(input logic [7:0] d);
    cfg_we = 1'b1; cfg_wdata = d; step(); cfg_we = 1'b0;
  endtask
  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(5ns * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    run(3);
    #1 chk(tx_valid == 1'b0, "R1", tx_valid, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk(tx_bit == RST_SEED[31], "R1", tx_bit, RST_SEED[31]);
    step();
    tx_ready = 1'b1;
    cur_req = "R6"; inv_cnt = 0; run(50);
    chk(inv_cnt == 0, "R6", inv_cnt, 0);

    cur_req = "R4";
    for (int i = 0; i < 200; i++) begin tx_ready = $urandom_range(0, 1); step(); end
    tx_ready = 1'b1;

    cur_req = "R2"; inv_cnt = 0; wr(8'h0E); run(30);
    chk(inv_cnt == 0, "R2", inv_cnt, 0);
    wr(8'h00);

    cur_req = "R5"; wr(8'h01);
    @(negedge clk); chk(tx_bit == seed[31], "R5", tx_bit, seed[31]);
    step(); run(20); wr(8'h01); run(20); wr(8'h00);
    seed = 32'hF0F0_1357; wr(8'h01);
    @(negedge clk); chk(tx_bit == seed[31], "R5", tx_bit, seed[31]);
    step(); wr(8'h00);

    cur_req = "R7 R11"; wr(8'h20); inv_cnt = 0; run(100);
    chk(inv_cnt == 10, "R7", inv_cnt, 10);
    wr(8'h40); inv_cnt = 0; run(250);
    chk(inv_cnt == 2, "R7", inv_cnt, 2);

    cur_req = "R8"; wr(8'h20); run(5); wr(8'h40); inv_cnt = 0; run(99);
    chk(inv_cnt == 0, "R8", inv_cnt, 0);
    run(1); chk(inv_cnt == 1, "R8", inv_cnt, 1);

    cur_req = "R7"; wr(8'hE0); inv_cnt = 0; run(3000);
    chk(inv_cnt == 0, "R7", inv_cnt, 0);

    cur_req = "R9 R11"; wr(8'h00); wr(8'h10); inv_cnt = 0; run(20);
    chk(inv_cnt == 1, "R9", inv_cnt, 1);
    inv_cnt = 0; wr(8'h10); run(20);
    chk(inv_cnt == 0, "R9", inv_cnt, 0);
    wr(8'h00); tx_ready = 1'b0; wr(8'h10); inv_cnt = 0; run(6);
    for (int i = 0; i < 40; i++) begin tx_ready = $urandom_range(0, 1); step(); end
    tx_ready = 1'b1; run(5);
    chk(inv_cnt == 1, "R9", inv_cnt, 1);

    cur_req = "R10"; wr(8'h00); wr(8'h20);
    while (m_cnt != 2) step();
    wr(8'h30); inv_cnt = 0; run(10);
    chk(inv_cnt == 1, "R10", inv_cnt, 1);
    cur_req = "R11"; run(40);

    done = 1'b1;
    summary();
  end
endmodule